// File: doc/BRIEF.md
# Decode-Stage Operand Forwarding Selector

This block sits in the decode stage of a five-stage in-order pipeline (fetch, decode, execute, memory, write-back). It is purely combinational. It works out the two source operand values, A and B, that the decode stage passes to execute. It does not simply take the register file read data. It compares each decode source register ID with the destination IDs of the three later stages. When an ID matches, it takes the newer result from that stage's bus instead of the stale register file value.

There are five candidate result buses:

- the ALU result being computed in execute;
- the load data being read in memory;
- the ALU result held in the memory pipeline register;
- the load data held in the write-back pipeline register;
- the ALU result held in the write-back pipeline register.

The youngest producer wins. For call and jump instructions, operand A carries the decode instruction's incremented PC, and that takes priority over any forwarded value. Operand B uses the same chain but never takes the PC.

A register ID of all ones (4'hF) means "no register". It never matches anything. The execute stage shows this ID in place of the real destination when a conditional move is not taken, so a cancelled move forwards nothing.

Top module: `fwd_operand_sel`

## Requirements
- R1: When the decode instruction code is 4'h7 (jump) or 4'h8 (call), operand A equals the decode incremented PC, whatever register IDs match.
- R2: If the source ID equals the execute destination ID, the operand is the execute ALU result, even when other stages also match.
- R3: If execute does not match but the memory load destination does, the operand is the memory load data.
- R4: If neither of the above matches but the memory ALU destination does, the operand is the memory ALU result.
- R5: If no execute or memory destination matches but the write-back load destination does, the operand is the write-back load data.
- R6: If the only match is the write-back ALU destination, the operand is the write-back ALU result.
- R7: With no match, the operand equals the register file read value for that port.
- R8: A source ID of 4'hF never forwards, even when destination IDs are also 4'hF. The operand is the register file value.
- R9: Operand B follows the R2 to R8 chain using the B source ID and the B register file value, and never takes the incremented PC, including for call and jump.
- R10: A destination ID of 4'hF, such as a cancelled conditional move in execute, is skipped. The next lower-priority match, or the register file, supplies the operand.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| d_src_a | input | 4 | Decode source register ID for operand A |
| d_src_b | input | 4 | Decode source register ID for operand B |
| d_rf_a | input | 64 | Register file read value for A |
| d_rf_b | input | 64 | Register file read value for B |
| d_pc_inc | input | 64 | Incremented PC of the decode instruction |
| d_icode | input | 4 | Decode instruction code |
| e_dst_alu | input | 4 | Execute destination ID (4'hF if cancelled) |
| e_alu_val | input | 64 | ALU result being computed in execute |
| m_dst_load | input | 4 | Memory-stage load destination ID |
| m_load_val | input | 64 | Load data being read in memory |
| m_dst_alu | input | 4 | Memory-stage ALU destination ID |
| m_alu_val | input | 64 | ALU result in the memory pipeline register |
| w_dst_load | input | 4 | Write-back load destination ID |
| w_load_val | input | 64 | Load data in the write-back pipeline register |
| w_dst_alu | input | 4 | Write-back ALU destination ID |
| w_alu_val | input | 64 | ALU result in the write-back pipeline register |
| opnd_a | output | 64 | Final operand A for execute |
| opnd_b | output | 64 | Final operand B for execute |

## Verification
The bench sweeps every source ID from 0 to 15 against all 32 patterns of which of the five destination IDs collide with it. It repeats each case for a plain instruction, a jump and a call. Every candidate bus carries a distinct value, so each result shows exactly which source won. This separates the five priority levels from each other and from the register file. It also separates PC selection on A from its absence on B. The sweeps with source ID 15 and with destination ID 15 show that the null ID neither matches nor blocks. A directed case puts 4'hF in execute while memory matches, and shows the cancelled move is skipped.

// File: rtl/fwd_pkg.sv
// Shared constants for the decode operand forwarding selector.
// Assumes a 4-bit instruction code with jump = 7 and call = 8.
package fwd_pkg;
    localparam int ICODE_W = 4;
    localparam logic [ICODE_W-1:0] IC_JUMP = 4'h7;
    localparam logic [ICODE_W-1:0] IC_CALL = 4'h8;

    // Index of each forwarding candidate; a lower index means a younger producer.
    typedef enum int {
        SRC_E_ALU  = 0,
        SRC_M_LOAD = 1,
        SRC_M_ALU  = 2,
        SRC_W_LOAD = 3,
        SRC_W_ALU  = 4,
        SRC_COUNT  = 5
    } fwd_src_e;

    // True for instructions whose A operand is the incremented PC.
    function automatic logic takes_pc(input logic [ICODE_W-1:0] ic);
        return (ic == IC_JUMP) || (ic == IC_CALL);
    endfunction
endpackage

// File: rtl/fwd_match.sv
// Hazard detector for one operand: flags every later-stage destination that
// equals the source ID. Assumes the all-ones ID means "no register" on either side.
module fwd_match #(
    parameter int RW = 4,
    parameter int N  = 5
) (
    input  logic [RW-1:0]        src,
    input  logic [N-1:0][RW-1:0] dst,
    output logic [N-1:0]         hit
);
    localparam logic [RW-1:0] NONE = '1;

    genvar i;
    generate
        for (i = 0; i < N; i++) begin : g_cmp
            // A candidate hits only on a real, equal register ID.
            assign hit[i] = (src != NONE) && (dst[i] == src);
        end
    endgenerate
endmodule

// File: rtl/fwd_pick.sv
// Priority picker: returns the value of the lowest-indexed hit, otherwise the
// fallback. Assumes candidates are ordered youngest first.
module fwd_pick #(
    parameter int DW = 64,
    parameter int N  = 5
) (
    input  logic [N-1:0]         hit,
    input  logic [N-1:0][DW-1:0] vals,
    input  logic [DW-1:0]        fallback,
    output logic [DW-1:0]        pick
);
    // Scan from the oldest up so that the youngest hit overwrites last.
    always_comb begin
        pick = fallback;
        for (int i = N - 1; i >= 0; i--) begin
            if (hit[i]) pick = vals[i];
        end
    end
endmodule

// File: rtl/fwd_operand_sel.sv
// Decode-stage operand selector. Operand A may be replaced by the incremented
// PC for call/jump; both operands otherwise take the youngest matching result
// among five later-stage buses, else the register file. Purely combinational;
// assumes destination IDs already show 4'hF for cancelled writes.
module fwd_operand_sel #(
    parameter int DW = 64,
    parameter int RW = 4
) (
    input  logic [RW-1:0] d_src_a,
    input  logic [RW-1:0] d_src_b,
    input  logic [DW-1:0] d_rf_a,
    input  logic [DW-1:0] d_rf_b,
    input  logic [DW-1:0] d_pc_inc,
    input  logic [3:0]    d_icode,
    input  logic [RW-1:0] e_dst_alu,
    input  logic [DW-1:0] e_alu_val,
    input  logic [RW-1:0] m_dst_load,
    input  logic [DW-1:0] m_load_val,
    input  logic [RW-1:0] m_dst_alu,
    input  logic [DW-1:0] m_alu_val,
    input  logic [RW-1:0] w_dst_load,
    input  logic [DW-1:0] w_load_val,
    input  logic [RW-1:0] w_dst_alu,
    input  logic [DW-1:0] w_alu_val,
    output logic [DW-1:0] opnd_a,
    output logic [DW-1:0] opnd_b
);
    import fwd_pkg::*;

    localparam int N    = int'(SRC_COUNT);
    localparam int NOPS = 2;
    localparam logic [RW-1:0] NONE = '1;

    logic [N-1:0][RW-1:0]    dsts;
    logic [N-1:0][DW-1:0]    vals;
    logic [NOPS-1:0][RW-1:0] srcs;
    logic [NOPS-1:0][DW-1:0] rfs;
    logic [NOPS-1:0][DW-1:0] fwd;
    logic [NOPS-1:0][N-1:0]  hits;
    logic                    use_pc;

    // Gather candidates in priority order (youngest first).
    always_comb begin
        dsts[SRC_E_ALU]  = e_dst_alu;   vals[SRC_E_ALU]  = e_alu_val;
        dsts[SRC_M_LOAD] = m_dst_load;  vals[SRC_M_LOAD] = m_load_val;
        dsts[SRC_M_ALU]  = m_dst_alu;   vals[SRC_M_ALU]  = m_alu_val;
        dsts[SRC_W_LOAD] = w_dst_load;  vals[SRC_W_LOAD] = w_load_val;
        dsts[SRC_W_ALU]  = w_dst_alu;   vals[SRC_W_ALU]  = w_alu_val;
        srcs[0] = d_src_a;  rfs[0] = d_rf_a;
        srcs[1] = d_src_b;  rfs[1] = d_rf_b;
    end

    genvar k;
    generate
        for (k = 0; k < NOPS; k++) begin : g_op
            fwd_match #(.RW(RW), .N(N)) u_match (
                .src (srcs[k]),
                .dst (dsts),
                .hit (hits[k])
            );
            fwd_pick #(.DW(DW), .N(N)) u_pick (
                .hit      (hits[k]),
                .vals     (vals),
                .fallback (rfs[k]),
                .pick     (fwd[k])
            );
        end
    endgenerate

    // Merge the incremented PC into A for call and jump.
    always_comb begin
        use_pc = takes_pc(d_icode);
        opnd_a = use_pc ? d_pc_inc : fwd[0];
        opnd_b = fwd[1];
    end

    // Port-level checks of the priority chain.
    always_comb begin
        if (d_icode == IC_CALL || d_icode == IC_JUMP)
            p_pc_on_a_r1: assert (opnd_a == d_pc_inc);
        if (d_src_a != NONE && e_dst_alu == d_src_a && d_icode != IC_CALL && d_icode != IC_JUMP)
            p_exec_first_r2: assert (opnd_a == e_alu_val);
        if (d_src_b != NONE && e_dst_alu == d_src_b)
            p_exec_first_b_r9: assert (opnd_b == e_alu_val);
        if (d_src_b != e_dst_alu && d_src_b != m_dst_load && d_src_b != m_dst_alu
            && d_src_b != w_dst_load && d_src_b != w_dst_alu)
            p_no_match_rf_r7: assert (opnd_b == d_rf_b);
        if (d_src_a == NONE && d_icode != IC_CALL && d_icode != IC_JUMP)
            p_null_src_r8: assert (opnd_a == d_rf_a);
        if (d_src_b == NONE)
            p_null_src_b_r8: assert (opnd_b == d_rf_b);
    end
endmodule

// File: tb/fwd_operand_sel_tb.sv
module fwd_operand_sel_tb;
    logic clk = 1'b0;
    always #2.5 clk = ~clk;

    logic [3:0]  d_src_a, d_src_b, d_icode;
    logic [63:0] d_rf_a, d_rf_b, d_pc_inc;
    logic [3:0]  e_dst_alu, m_dst_load, m_dst_alu, w_dst_load, w_dst_alu;
    logic [63:0] e_alu_val, m_load_val, m_alu_val, w_load_val, w_alu_val;
    logic [63:0] opnd_a, opnd_b;

    int total = 0;
    int bad   = 0;
    bit done  = 0;

    fwd_operand_sel u_dut (
        .d_src_a(d_src_a), .d_src_b(d_src_b), .d_rf_a(d_rf_a), .d_rf_b(d_rf_b),
        .d_pc_inc(d_pc_inc), .d_icode(d_icode),
        .e_dst_alu(e_dst_alu), .e_alu_val(e_alu_val),
        .m_dst_load(m_dst_load), .m_load_val(m_load_val),
        .m_dst_alu(m_dst_alu), .m_alu_val(m_alu_val),
        .w_dst_load(w_dst_load), .w_load_val(w_load_val),
        .w_dst_alu(w_dst_alu), .w_alu_val(w_alu_val),
        .opnd_a(opnd_a), .opnd_b(opnd_b)
    );

    function automatic string tag_of(input int w);
        case (w)
            0: return "R2";
            1: return "R3";
            2: return "R4";
            3: return "R5";
            4: return "R6";
            default: return "R7";
        endcase
    endfunction

    task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    function automatic logic [63:0] cand_val(input int i, input int seed);
        return 64'hC0DE_0000_0000_0000 | (64'(i + 1) << 32) | 64'(seed);
    endfunction

    task automatic apply(input logic [3:0] s, input int mask, input logic [3:0] ic, input int seed);
        logic [3:0] d [5];
        for (int i = 0; i < 5; i++) begin
            if (mask[i]) d[i] = s;
            else if (s == 4'hF) d[i] = 4'(i);
            else d[i] = 4'((int'(s) + 1 + i) % 15);
        end
        d_src_a = s; d_src_b = s; d_icode = ic;
        d_rf_a = 64'hAAAA_0000_0000_0000 | 64'(seed);
        d_rf_b = 64'hBBBB_0000_0000_0000 | 64'(seed);
        d_pc_inc = 64'h9C00_0000_0000_0000 | 64'(seed);
        e_dst_alu = d[0];  e_alu_val  = cand_val(0, seed);
        m_dst_load = d[1]; m_load_val = cand_val(1, seed);
        m_dst_alu = d[2];  m_alu_val  = cand_val(2, seed);
        w_dst_load = d[3]; w_load_val = cand_val(3, seed);
        w_dst_alu = d[4];  w_alu_val  = cand_val(4, seed);
    endtask

    initial begin
        #(5 * 150000);
        if (!done) begin
            total++; bad++;
            $display("FAIL watchdog: run hung");
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        int seed = 0;
        // Idle pattern: nothing matches, plain instruction (R7).
        apply(4'h3, 0, 4'h0, 0);
        @(negedge clk);
        check("R7 idle A", opnd_a, d_rf_a);
        check("R7 idle B", opnd_b, d_rf_b);

        for (int s = 0; s < 16; s++) begin
            for (int m = 0; m < 32; m++) begin
                for (int c = 0; c < 3; c++) begin
                    logic [3:0] ic;
                    int win;
                    logic [63:0] exp_f;
                    string t;
                    ic = (c == 0) ? 4'h0 : ((c == 1) ? 4'h7 : 4'h8);
                    seed++;
                    apply(4'(s), m, ic, seed);
                    @(negedge clk);
                    win = 5;
                    if (s != 15) begin
                        for (int i = 4; i >= 0; i--) if (m[i]) win = i;
                    end
                    exp_f = (win == 5) ? d_rf_b : cand_val(win, seed);
                    t = (s == 15) ? "R8" : tag_of(win);
                    if (c != 0)
                        check("R1 pc on A", opnd_a, d_pc_inc);
                    else
                        check(t, opnd_a, (win == 5) ? d_rf_a : cand_val(win, seed));
                    check((c != 0) ? "R9 B ignores pc" : "R9 B chain", opnd_b, exp_f);
                end
            end
        end

        // Cancelled move in execute (ID 4'hF): memory ALU should win.
        apply(4'h3, 5'b00100, 4'h0, 7);
        e_dst_alu = 4'hF;
        @(negedge clk);
        check("R10 cancelled exec A", opnd_a, cand_val(2, 7));
        check("R10 cancelled exec B", opnd_b, cand_val(2, 7));
        // All destinations null, source real: register file.
        apply(4'h5, 0, 4'h0, 8);
        e_dst_alu = 4'hF; m_dst_load = 4'hF; m_dst_alu = 4'hF; w_dst_load = 4'hF; w_dst_alu = 4'hF;
        @(negedge clk);
        check("R10 all null dst", opnd_a, d_rf_a);
        // Null source against null destinations.
        d_src_a = 4'hF; d_src_b = 4'hF;
        @(negedge clk);
        check("R8 null vs null A", opnd_a, d_rf_a);
        check("R8 null vs null B", opnd_b, d_rf_b);

        done = 1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule